// File: doc/BRIEF.md
# Host PORT Command Decoder

This block sits between a host and the internal engines of a network coprocessor. The host issues a PORT command as two 16-bit write strobes. The first strobe carries the low half-word and freezes the internal engines. The second strobe carries the high half-word and triggers the command. In the resulting 32-bit word, bits 3:0 are a function code and bits 31:4 form a 16-byte-aligned address.

Four function codes start an action: software reset, self-test with a results address, loading an alternative configuration-pointer address, and dump with a dump-area address. Each action is a single-cycle pulse, and the address is presented alongside it. All other codes only release the freeze. The engines that perform self-test and dump sit outside this block.

After a software reset the block keeps a quiet window open. A channel attention that arrives inside this window is dropped and flagged. The window closes only after at least ten system clocks have passed and five rising edges of a separate, asynchronous serial clock have been seen. A channel attention that arrives after the window has closed is accepted and starts a fresh initialization.

Top module: `host_port_decoder`

## Requirements
- R1: While reset is asserted, and directly after it, holdEngines, all four action pulses, quietBusy, attnAccept and attnDropped are 0, and actionAddr is 0.
- R2: A portStrobe in the idle state captures portData as bits 15:0 of the command. holdEngines is 1 from the next cycle and stays 1, whatever portData does, until the second portStrobe.
- R3: The second portStrobe captures portData as bits 31:16. In the next cycle holdEngines is 0 and exactly one pulse is high for one cycle, chosen by bits 3:0: 0000 gives resetPulse, 0001 gives selfTestPulse, 0010 gives altCfgPulse, 0011 gives dumpPulse.
- R4: During a selfTestPulse, altCfgPulse or dumpPulse, actionAddr equals the command word with bits 3:0 forced to 0.
- R5: During a resetPulse, actionAddr is 0 whatever address bits were written.
- R6: Function codes 0100 through 1111 produce no pulse, and holdEngines returns to 0 in the cycle after the second strobe.
- R7: quietBusy is 1 in the cycle of resetPulse. It stays 1 for at least 10 system clock cycles from then on.
- R8: quietBusy stays 1 until 5 rising edges of serialClk have been seen after the reset command. serialClk passes through a two-stage synchronizer first. quietBusy then falls once both limits are met.
- R9: A chanAttn sampled while quietBusy is 1 gives a one-cycle attnDropped in the next cycle and no attnAccept.
- R10: A chanAttn sampled while quietBusy is 0 gives a one-cycle attnAccept in the next cycle and no attnDropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| portStrobe | input | 1 | One-cycle write strobe for a command half-word |
| portData | input | 16 | Half-word data from the host |
| serialClk | input | 1 | Asynchronous serial clock, counted for the quiet window |
| chanAttn | input | 1 | One-cycle channel attention request |
| holdEngines | output | 1 | Freezes the internal engines between the two halves |
| resetPulse | output | 1 | Software reset action |
| selfTestPulse | output | 1 | Self-test action |
| altCfgPulse | output | 1 | Load alternative configuration-pointer address |
| dumpPulse | output | 1 | Dump action |
| actionAddr | output | 32 | Aligned address that accompanies an action |
| quietBusy | output | 1 | Quiet window after reset is open |
| attnAccept | output | 1 | Channel attention accepted |
| attnDropped | output | 1 | Channel attention rejected during the quiet window |

## Verification
The assertions assume three things about the inputs: portStrobe and chanAttn are synchronous to clk, they are known after reset, and each write or request lasts a single cycle. serialClk may change at any time, because only its synchronized copy is observed. The stimulus keeps to these rules by changing every input on the falling clock edge and raising each strobe for exactly one cycle. serialClk is toggled either by a free-running process or by slow, hand-placed edges.

// File: rtl/hpd_pkg.sv
package hpd_pkg;
  localparam int FN_W = 4;

  localparam logic [FN_W-1:0] FN_SOFT_RESET = 4'h0;
  localparam logic [FN_W-1:0] FN_SELF_TEST  = 4'h1;
  localparam logic [FN_W-1:0] FN_ALT_CFG    = 4'h2;
  localparam logic [FN_W-1:0] FN_DUMP       = 4'h3;

  typedef enum logic {ST_IDLE = 1'b0, ST_HALF = 1'b1} cmdState_e;

  typedef struct packed {
    logic captureLo;
    logic captureHi;
    logic startQuiet;
    logic tickQuiet;
  } dpStrobes_t;
endpackage

// File: rtl/hpd_datapath.sv
module hpd_datapath
  import hpd_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYS_QUIET   = 10,
  parameter int SER_QUIET   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dpStrobes_t          strobes,
  input  logic [HALF_W-1:0]   portData,
  input  logic                serialClk,
  output logic [FN_W-1:0]     fnCode,
  output logic [2*HALF_W-1:0] actionAddr,
  output logic                quietDone
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int SYS_W  = $clog2(SYS_QUIET + 1);
  localparam int SER_W  = $clog2(SER_QUIET + 1);

  logic [HALF_W-1:0]    loWord;
  logic [WORD_W-1:0]    addrReg;
  logic [SYNC_STAGES:0] serSync;
  logic                 serRise;
  logic [SYS_W-1:0]     sysCnt;
  logic [SER_W-1:0]     serCnt;

  assign fnCode     = loWord[FN_W-1:0];
  assign actionAddr = addrReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loWord  <= '0;
      addrReg <= '0;
    end else begin
      if (strobes.captureLo) loWord <= portData;
      if (strobes.captureHi) begin
        if (loWord[FN_W-1:0] == FN_SOFT_RESET) addrReg <= '0;
        else addrReg <= {portData, loWord[HALF_W-1:FN_W], {FN_W{1'b0}}};
      end
    end
  end

  // Synchronizer stages followed by one delay stage used for edge detection
  genvar gi;
  for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rstN) serSync[gi] <= 1'b0;
      else if (gi == 0) serSync[gi] <= serialClk;
      else serSync[gi] <= serSync[(gi == 0) ? 0 : gi-1];
    end
  end

  assign serRise = serSync[SYNC_STAGES-1] & ~serSync[SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sysCnt <= '0;
      serCnt <= '0;
    end else if (strobes.startQuiet) begin
      sysCnt <= '0;
      serCnt <= '0;
    end else if (strobes.tickQuiet) begin
      if (sysCnt != SYS_W'(SYS_QUIET)) sysCnt <= sysCnt + 1'b1;
      if (serRise && serCnt != SER_W'(SER_QUIET)) serCnt <= serCnt + 1'b1;
    end
  end

  assign quietDone = (sysCnt == SYS_W'(SYS_QUIET)) && (serCnt == SER_W'(SER_QUIET));
endmodule

// File: rtl/hpd_control.sv
module hpd_control
  import hpd_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            portStrobe,
  input  logic            chanAttn,
  input  logic [FN_W-1:0] fnCode,
  input  logic            quietDone,
  output dpStrobes_t      strobes,
  output logic            holdEngines,
  output logic            resetPulse,
  output logic            selfTestPulse,
  output logic            altCfgPulse,
  output logic            dumpPulse,
  output logic            quietBusy,
  output logic            attnAccept,
  output logic            attnDropped
);
  cmdState_e state;

  always_comb begin
    strobes.captureLo  = portStrobe && (state == ST_IDLE);
    strobes.captureHi  = portStrobe && (state == ST_HALF);
    strobes.startQuiet = strobes.captureHi && (fnCode == FN_SOFT_RESET);
    strobes.tickQuiet  = quietBusy;
  end

  assign holdEngines = (state == ST_HALF);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      resetPulse    <= 1'b0;
      selfTestPulse <= 1'b0;
      altCfgPulse   <= 1'b0;
      dumpPulse     <= 1'b0;
      quietBusy     <= 1'b0;
      attnAccept    <= 1'b0;
      attnDropped   <= 1'b0;
    end else begin
      if (strobes.captureLo) state <= ST_HALF;
      else if (strobes.captureHi) state <= ST_IDLE;

      resetPulse    <= strobes.captureHi && (fnCode == FN_SOFT_RESET);
      selfTestPulse <= strobes.captureHi && (fnCode == FN_SELF_TEST);
      altCfgPulse   <= strobes.captureHi && (fnCode == FN_ALT_CFG);
      dumpPulse     <= strobes.captureHi && (fnCode == FN_DUMP);

      if (strobes.startQuiet) quietBusy <= 1'b1;
      else if (quietDone) quietBusy <= 1'b0;

      attnAccept  <= chanAttn && !quietBusy;
      attnDropped <= chanAttn && quietBusy;
    end
  end
endmodule

// File: rtl/host_port_decoder.sv
module host_port_decoder
  import hpd_pkg::*;
#(
  parameter int HALF_W      = 16,
  parameter int SYS_QUIET   = 10,
  parameter int SER_QUIET   = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                portStrobe,
  input  logic [HALF_W-1:0]   portData,
  input  logic                serialClk,
  input  logic                chanAttn,
  output logic                holdEngines,
  output logic                resetPulse,
  output logic                selfTestPulse,
  output logic                altCfgPulse,
  output logic                dumpPulse,
  output logic [2*HALF_W-1:0] actionAddr,
  output logic                quietBusy,
  output logic                attnAccept,
  output logic                attnDropped
);
  dpStrobes_t      strobes;
  logic [FN_W-1:0] fnCode;
  logic            quietDone;

  hpd_control u_ctrl (
    .clk(clk), .rstN(rstN), .portStrobe(portStrobe), .chanAttn(chanAttn),
    .fnCode(fnCode), .quietDone(quietDone), .strobes(strobes),
    .holdEngines(holdEngines), .resetPulse(resetPulse),
    .selfTestPulse(selfTestPulse), .altCfgPulse(altCfgPulse),
    .dumpPulse(dumpPulse), .quietBusy(quietBusy),
    .attnAccept(attnAccept), .attnDropped(attnDropped)
  );

  hpd_datapath #(
    .HALF_W(HALF_W), .SYS_QUIET(SYS_QUIET),
    .SER_QUIET(SER_QUIET), .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .portData(portData),
    .serialClk(serialClk), .fnCode(fnCode), .actionAddr(actionAddr),
    .quietDone(quietDone)
  );
endmodule

// File: rtl/hpd_checker.sv
module hpd_checker #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rstN,
  input logic                portStrobe,
  input logic                chanAttn,
  input logic                holdEngines,
  input logic                resetPulse,
  input logic                selfTestPulse,
  input logic                altCfgPulse,
  input logic                dumpPulse,
  input logic [2*HALF_W-1:0] actionAddr,
  input logic                quietBusy,
  input logic                attnAccept,
  input logic                attnDropped
);
  logic anyPulse;
  assign anyPulse = resetPulse | selfTestPulse | altCfgPulse | dumpPulse;

  // R2
  hold_on_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!holdEngines && portStrobe) |=> holdEngines);

  // R3
  hold_off_second_chk: assert property (@(posedge clk) disable iff (!rstN)
    (holdEngines && portStrobe) |=> !holdEngines);

  // R3
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({resetPulse, selfTestPulse, altCfgPulse, dumpPulse}));

  // R3
  action_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |-> ($past(holdEngines) && $past(portStrobe)));

  // R4
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyPulse |-> (actionAddr[3:0] == 4'h0));

  // R5
  reset_addr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> (actionAddr == '0));

  // R7
  quiet_opens_chk: assert property (@(posedge clk) disable iff (!rstN)
    resetPulse |-> quietBusy);

  // R9
  attn_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanAttn && quietBusy) |=> (attnDropped && !attnAccept));

  // R10
  attn_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (chanAttn && !quietBusy) |=> (attnAccept && !attnDropped));
endmodule

bind host_port_decoder hpd_checker #(.HALF_W(HALF_W)) u_chk (.*);

// File: tb/host_port_decoder_tb.sv
module host_port_decoder_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portStrobe = 1'b0;
  logic [15:0] portData = '0;
  logic        serialClk = 1'b0;
  logic        chanAttn = 1'b0;
  logic        serialRun = 1'b0;
  logic        holdEngines, resetPulse, selfTestPulse, altCfgPulse, dumpPulse;
  logic [31:0] actionAddr;
  logic        quietBusy, attnAccept, attnDropped;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_port_decoder u_dut (
    .clk(clk), .rstN(rstN), .portStrobe(portStrobe), .portData(portData),
    .serialClk(serialClk), .chanAttn(chanAttn), .holdEngines(holdEngines),
    .resetPulse(resetPulse), .selfTestPulse(selfTestPulse),
    .altCfgPulse(altCfgPulse), .dumpPulse(dumpPulse), .actionAddr(actionAddr),
    .quietBusy(quietBusy), .attnAccept(attnAccept), .attnDropped(attnDropped)
  );

  initial forever begin
    @(negedge clk);
    if (serialRun) serialClk = ~serialClk;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] pulseVec();
    return {dumpPulse, altCfgPulse, selfTestPulse, resetPulse};
  endfunction

  // Ends at the falling edge where the action pulse is visible
  task automatic sendCmd(input logic [31:0] word, input int gap);
    logic [3:0]  expPulse;
    logic [31:0] expAddr;
    expPulse = (word[3:0] < 4) ? (4'b0001 << word[3:0]) : 4'b0000;
    expAddr  = (word[3:0] == 4'h0) ? 32'h0 : {word[31:4], 4'h0};
    @(negedge clk);
    portStrobe = 1'b1; portData = word[15:0];
    @(negedge clk);
    portStrobe = 1'b0; portData = ~word[15:0];
    check(holdEngines == 1'b1, "R2", "hold after first write", 64'(holdEngines), 64'd1);
    repeat (gap) @(negedge clk);
    portStrobe = 1'b1; portData = word[31:16];
    @(negedge clk);
    portStrobe = 1'b0; portData = 16'h0;
    if (word[3:0] < 4)
      check(pulseVec() == expPulse, "R3", "action pulse", 64'(pulseVec()), 64'(expPulse));
    else
      check(pulseVec() == 4'b0, "R6", "no pulse for spare code", 64'(pulseVec()), 64'd0);
    check(holdEngines == 1'b0, word[3:0] < 4 ? "R3" : "R6", "hold released",
          64'(holdEngines), 64'd0);
    if (word[3:0] == 4'h0)
      check(actionAddr == 32'h0, "R5", "reset address", 64'(actionAddr), 64'd0);
    else if (word[3:0] < 4)
      check(actionAddr == expAddr, "R4", "action address", 64'(actionAddr), 64'(expAddr));
  endtask

  task automatic serialEdge();
    serialClk = 1'b1;
    repeat (3) @(negedge clk);
    serialClk = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFF0;
    pats[2] = 32'hA5C3_9E70; pats[3] = 32'h1234_5670;

    // R1: reset state
    repeat (3) @(negedge clk);
    check({holdEngines, pulseVec(), quietBusy, attnAccept, attnDropped} == 8'h0,
          "R1", "outputs in reset", 64'({holdEngines, pulseVec(), quietBusy}), 64'd0);
    check(actionAddr == 32'h0, "R1", "address in reset", 64'(actionAddr), 64'd0);
    rstN = 1'b1;
    @(negedge clk);
    check({holdEngines, pulseVec(), quietBusy} == 6'h0, "R1", "outputs after reset",
          64'({holdEngines, pulseVec(), quietBusy}), 64'd0);

    // Sweep every code over several address patterns, R3 R4 R5 R6
    serialRun = 1'b1;
    foreach (pats[p]) begin
      for (int code = 0; code < 16; code++) begin
        sendCmd(pats[p] | 32'(code), code % 3);
        @(negedge clk);
        check(pulseVec() == 4'b0, "R3", "pulse lasts one cycle", 64'(pulseVec()), 64'd0);
      end
    end

    // R7 and R9 with a fast serial clock
    repeat (40) @(negedge clk);
    sendCmd(32'hCAFE_BAB0, 0);
    check(quietBusy == 1'b1, "R7", "quiet opens with reset", 64'(quietBusy), 64'd1);
    repeat (9) @(negedge clk);
    check(quietBusy == 1'b1, "R7", "quiet still open at 10 cycles", 64'(quietBusy), 64'd1);
    chanAttn = 1'b1;
    @(negedge clk);
    chanAttn = 1'b0;
    check(attnDropped == 1'b1 && attnAccept == 1'b0, "R9", "attention dropped",
          64'({attnDropped, attnAccept}), 64'h2);
    repeat (30) @(negedge clk);
    check(quietBusy == 1'b0, "R7", "quiet closed", 64'(quietBusy), 64'd0);
    chanAttn = 1'b1;
    @(negedge clk);
    chanAttn = 1'b0;
    check(attnAccept == 1'b1 && attnDropped == 1'b0, "R10", "attention accepted",
          64'({attnDropped, attnAccept}), 64'h1);
    @(negedge clk);
    check(attnAccept == 1'b0, "R10", "accept lasts one cycle", 64'(attnAccept), 64'd0);

    // R8: serial edges gate the end of the quiet window
    serialRun = 1'b0;
    serialClk = 1'b0;
    repeat (5) @(negedge clk);
    sendCmd(32'h0000_0000, 1);
    repeat (40) @(negedge clk);
    check(quietBusy == 1'b1, "R8", "no serial edges keeps quiet", 64'(quietBusy), 64'd1);
    for (int e = 0; e < 4; e++) serialEdge();
    repeat (10) @(negedge clk);
    check(quietBusy == 1'b1, "R8", "four serial edges keep quiet", 64'(quietBusy), 64'd1);
    serialEdge();
    repeat (10) @(negedge clk);
    check(quietBusy == 1'b0, "R8", "fifth serial edge closes quiet", 64'(quietBusy), 64'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule